// File: doc/BRIEF.md
# Write-Only Two-Wire Slave Receiver

This block is the receiving front end of a two-wire serial slave that only accepts writes. Both bus lines are brought into a fast system clock domain through two-flop synchronisers. Each line then goes through a filter that needs several consecutive samples before it accepts a new level. From the filtered lines the block finds START, repeated START and STOP conditions and shifts in bytes with the most significant bit first. It compares the first byte after each START against the device's own 7-bit address and pulls SDA low in the ninth clock to acknowledge.

The address begins with the fixed bits 010. A parameter picks how the four remaining bits are made. Either two of them are fixed high and two come from strap pins, or all four come from strap pins. When the address matches, the block forwards each data byte that follows to a separate command decoder. Each such byte comes with a one-cycle valid strobe. The block also gives the decoder a START pulse, a STOP pulse and a level that is high while the device is selected. Reads, clock stretching and general call are not handled.

Top module: `twr_slave_rx`

## Requirements
- R1: A falling edge of filtered SDA while filtered SCL stays high gives a one-cycle `start_o` pulse. A rising edge of SDA while SCL stays high is a STOP condition.
- R2: Each data byte after a matching address is assembled MSB first and presented on `rx_byte_o`, with `rx_valid_o` high for exactly one cycle per byte.
- R3: The own address is {010, 1, 1, strap[1:0]} when `ADDR_PINS` is 2 and {010, strap[3:0]} when it is 4. The address byte carries the 7 address bits in bits 7:1 and the direction in bit 0. The byte is acknowledged only when bits 7:1 equal the own address.
- R4: An address byte that matches but has bit 0 = 1 (a read) is not acknowledged and does not select the device.
- R5: `sda_oe_o` (1 = pull SDA low) is asserted from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth clock. This happens for a matching write address byte and for every data byte after it, and never otherwise.
- R6: `addressed_o` rises after a matching write address byte and falls on any START or STOP. After a repeated START with a different address it stays low.
- R7: `stop_o` pulses for one cycle on a STOP only when the device was selected at that moment.
- R8: A change on SCL or SDA lasting fewer than `FILT_LEN` system clocks has no effect. With the default of 4, a 2-cycle SDA dip on an idle bus gives no START, while a 10-cycle dip does.
- R9: A START or STOP in the middle of a byte discards the partial byte: no `rx_valid_o`, and bit counting restarts.
- R10: While reset is held, `sda_oe_o`, `addressed_o`, `rx_valid_o`, `start_o` and `stop_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_strap_i | input | ADDR_PINS | Strap pins for the low address bits |
| sda_oe_o | output | 1 | 1 = drive SDA low (acknowledge) |
| rx_byte_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new data byte |
| start_o | output | 1 | One-cycle pulse on START or repeated START |
| stop_o | output | 1 | One-cycle pulse on STOP while selected |
| addressed_o | output | 1 | High while this device is selected |

## Verification
The hardest case to reach is a bus condition that lands inside a byte. The block must throw away a partial shift and restart cleanly, and it must not emit a strobe. The bench builds this from bit-level master tasks. It sends only a few bits of a data byte and then issues a repeated START or a STOP instead of the remaining bits. It then checks the strobe count and the selected state. The glitch filter is exercised in a similar way, by holding SDA low on an idle bus for a cycle count just below and well above the filter length.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam logic [2:0] ADDR_PREFIX = 3'b010;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } rx_phase_e;
endpackage

// File: rtl/twr_sync_filter.sv
module twr_sync_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], raw_i};
    end
  end

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (sync_q[1] != filt_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q)); // R8
endmodule

// File: rtl/twr_edge_detect.sv
module twr_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_ev_o,
  output logic stop_ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  always_comb begin
    scl_rise_o = scl_f_i & ~scl_q;
    scl_fall_o = ~scl_f_i & scl_q;
    start_ev_o = scl_f_i & scl_q & sda_q & ~sda_f_i;
    stop_ev_o  = scl_f_i & scl_q & ~sda_q & sda_f_i;
  end

  AST_COND_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev_o || stop_ev_o) |-> $past(scl_f_i)); // R1
endmodule

// File: rtl/twr_addr_match.sv
module twr_addr_match
  import twr_pkg::*;
#(
  parameter int ADDR_PINS = 2
) (
  input  logic [ADDR_PINS-1:0] strap_i,
  input  logic [BYTE_W-1:0]    cand_i,
  output logic                 hit_o
);
  logic [ADDR_W-1:0] own_addr;

  generate
    if (ADDR_PINS == 4) begin : g_four_pins
      assign own_addr = {ADDR_PREFIX, strap_i};
    end else begin : g_two_pins
      assign own_addr = {ADDR_PREFIX, 2'b11, strap_i};
    end
  endgenerate

  assign hit_o = (cand_i[BYTE_W-1:1] == own_addr) && !cand_i[0];
endmodule

// File: rtl/twr_rx_engine.sv
module twr_rx_engine
  import twr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_ev_i,
  input  logic              stop_ev_i,
  input  logic              addr_hit_i,
  output logic [BYTE_W-1:0] cand_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              addressed_o
);
  localparam int BCW      = $clog2(BYTE_W + 2);
  localparam int LAST_BIT = BYTE_W - 1;
  localparam int ACK_LOW  = BYTE_W;
  localparam int ACK_HIGH = BYTE_W + 1;

  rx_phase_e         phase_q, phase_d;
  logic [BCW-1:0]    bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] rx_byte_q, rx_byte_d;
  logic              addressed_q, addressed_d;
  logic              ack_arm_q, ack_arm_d;
  logic              sda_oe_q, sda_oe_d;
  logic              rx_valid_q, rx_valid_d;
  logic              start_q, start_d;
  logic              stop_q, stop_d;

  assign cand_o = {shift_q[BYTE_W-2:0], sda_f_i};

  always_comb begin
    phase_d     = phase_q;
    bitcnt_d    = bitcnt_q;
    shift_d     = shift_q;
    rx_byte_d   = rx_byte_q;
    addressed_d = addressed_q;
    ack_arm_d   = ack_arm_q;
    sda_oe_d    = sda_oe_q;
    rx_valid_d  = 1'b0;
    start_d     = 1'b0;
    stop_d      = 1'b0;

    if (start_ev_i) begin
      phase_d     = PH_ADDR;
      bitcnt_d    = '0;
      addressed_d = 1'b0;
      ack_arm_d   = 1'b0;
      sda_oe_d    = 1'b0;
      start_d     = 1'b1;
    end else if (stop_ev_i) begin
      phase_d     = PH_IDLE;
      bitcnt_d    = '0;
      addressed_d = 1'b0;
      ack_arm_d   = 1'b0;
      sda_oe_d    = 1'b0;
      stop_d      = addressed_q;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise_i) begin
        if (bitcnt_q < BCW'(ACK_LOW)) begin
          shift_d  = cand_o;
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == BCW'(LAST_BIT)) begin
            if (phase_q == PH_ADDR) begin
              if (addr_hit_i) begin
                addressed_d = 1'b1;
                ack_arm_d   = 1'b1;
                phase_d     = PH_DATA;
              end else begin
                phase_d = PH_IDLE;
              end
            end else begin
              rx_valid_d = 1'b1;
              rx_byte_d  = cand_o;
              ack_arm_d  = 1'b1;
            end
          end
        end else if (bitcnt_q == BCW'(ACK_LOW)) begin
          bitcnt_d = BCW'(ACK_HIGH);
        end
      end else if (scl_fall_i) begin
        if (bitcnt_q == BCW'(ACK_LOW) && ack_arm_q) begin
          sda_oe_d  = 1'b1;
          ack_arm_d = 1'b0;
        end else if (bitcnt_q == BCW'(ACK_HIGH)) begin
          sda_oe_d = 1'b0;
          bitcnt_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      bitcnt_q    <= '0;
      shift_q     <= '0;
      rx_byte_q   <= '0;
      addressed_q <= 1'b0;
      ack_arm_q   <= 1'b0;
      sda_oe_q    <= 1'b0;
      rx_valid_q  <= 1'b0;
      start_q     <= 1'b0;
      stop_q      <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      bitcnt_q    <= bitcnt_d;
      shift_q     <= shift_d;
      rx_byte_q   <= rx_byte_d;
      addressed_q <= addressed_d;
      ack_arm_q   <= ack_arm_d;
      sda_oe_q    <= sda_oe_d;
      rx_valid_q  <= rx_valid_d;
      start_q     <= start_d;
      stop_q      <= stop_d;
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign rx_byte_o   = rx_byte_q;
  assign rx_valid_o  = rx_valid_q;
  assign start_o     = start_q;
  assign stop_o      = stop_q;
  assign addressed_o = addressed_q;

  AST_OE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_q |-> addressed_q); // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |=> !rx_valid_q); // R2
  AST_VALID_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> addressed_q); // R2
  AST_STOP_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> $past(addressed_q)); // R7
  AST_START_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !addressed_q); // R6
  AST_START_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !rx_valid_q); // R9
endmodule

// File: rtl/twr_slave_rx.sv
module twr_slave_rx
  import twr_pkg::*;
#(
  parameter int FILT_LEN  = 4,
  parameter int ADDR_PINS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [ADDR_PINS-1:0] addr_strap_i,
  output logic                 sda_oe_o,
  output logic [BYTE_W-1:0]    rx_byte_o,
  output logic                 rx_valid_o,
  output logic                 start_o,
  output logic                 stop_o,
  output logic                 addressed_o
);
  localparam int NLINES = 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_s_n;
  logic [NLINES-1:0] raw_lines, filt_lines;
  logic              scl_rise, scl_fall, start_ev, stop_ev, addr_hit;
  logic [BYTE_W-1:0] cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe_q[1];

  assign raw_lines = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      twr_sync_filter #(.FILT_LEN(FILT_LEN)) i_filt (
        .clk    (clk),
        .rst_n  (rst_s_n),
        .raw_i  (raw_lines[g]),
        .filt_o (filt_lines[g])
      );
    end
  endgenerate

  twr_edge_detect i_edge (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .scl_f_i    (filt_lines[0]),
    .sda_f_i    (filt_lines[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_ev_o (start_ev),
    .stop_ev_o  (stop_ev)
  );

  twr_addr_match #(.ADDR_PINS(ADDR_PINS)) i_match (
    .strap_i (addr_strap_i),
    .cand_i  (cand),
    .hit_o   (addr_hit)
  );

  twr_rx_engine i_engine (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .sda_f_i     (filt_lines[1]),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_ev_i  (start_ev),
    .stop_ev_i   (stop_ev),
    .addr_hit_i  (addr_hit),
    .cand_o      (cand),
    .sda_oe_o    (sda_oe_o),
    .rx_byte_o   (rx_byte_o),
    .rx_valid_o  (rx_valid_o),
    .start_o     (start_o),
    .stop_o      (stop_o),
    .addressed_o (addressed_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s_n |-> !(sda_oe_o || addressed_o || rx_valid_o)); // R10
endmodule

// File: tb/test_twr_slave_rx.sv
module test_twr_slave_rx;
  localparam int Q = 25;

  logic       clk, rst_n, scl_m, sda_m;
  logic [1:0] strap;
  logic       sda_oe, rx_valid, start_p, stop_p, addressed;
  logic [7:0] rx_byte;
  logic       sda_line;

  int n_chk = 0, n_err = 0;
  int n_start = 0, n_stop = 0, n_valid = 0;
  logic [7:0] blog [16];
  bit done = 0;

  assign sda_line = sda_m & ~sda_oe;

  twr_slave_rx i_twr_slave_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .addr_strap_i (strap),
    .sda_oe_o     (sda_oe),
    .rx_byte_o    (rx_byte),
    .rx_valid_o   (rx_valid),
    .start_o      (start_p),
    .stop_o       (stop_p),
    .addressed_o  (addressed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (start_p) n_start++;
    if (stop_p) n_stop++;
    if (rx_valid) begin
      blog[n_valid % 16] = rx_byte;
      n_valid++;
    end
  end

  // {strap, address byte, data byte, expect address ack, expect data accepted}
  localparam logic [19:0] VEC [0:6] = '{
    {2'b01, 8'h5A, 8'hA5, 1'b1, 1'b1},
    {2'b10, 8'h5C, 8'h3C, 1'b1, 1'b1},
    {2'b01, 8'h5C, 8'h77, 1'b0, 1'b0},
    {2'b00, 8'h59, 8'h11, 1'b0, 1'b0},
    {2'b11, 8'h5E, 8'h00, 1'b1, 1'b1},
    {2'b11, 8'h4E, 8'hFF, 1'b0, 1'b0},
    {2'b00, 8'h58, 8'hFF, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int k = 0; k < n; k++) begin
      sda_m = b[7 - k]; tick(Q);
      scl_m = 1'b1;     tick(2 * Q);
      scl_m = 1'b0;     tick(Q);
    end
  endtask

  task automatic ack_clock(output logic a);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    a = sda_oe;   tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  initial begin
    logic [19:0] v;
    logic        a1, a2;
    int          s0, p0, c0;

    scl_m = 1'b1; sda_m = 1'b1; strap = 2'b01; rst_n = 1'b0;
    tick(5);
    chk("R10 oe in reset", int'(sda_oe), 0);
    chk("R10 addressed in reset", int'(addressed), 0);
    chk("R10 pulses in reset", int'(rx_valid | start_p | stop_p), 0);
    rst_n = 1'b1;
    tick(10);

    for (int i = 0; i < 7; i++) begin
      v = VEC[i];
      strap = v[19:18];
      tick(4);
      s0 = n_start; p0 = n_stop; c0 = n_valid;
      bus_start();
      send_bits(v[17:10], 8);
      ack_clock(a1);
      send_bits(v[9:2], 8);
      ack_clock(a2);
      bus_stop();
      tick(20);
      chk("R1 start pulse per transfer", n_start - s0, 1);
      chk("R3 R4 address ack", int'(a1), int'(v[1]));
      chk("R5 data ack", int'(a2), int'(v[0]));
      chk("R2 strobe count", n_valid - c0, int'(v[0]));
      if (v[0]) chk("R2 byte value", int'(blog[c0 % 16]), int'(v[9:2]));
      chk("R7 stop pulse", n_stop - p0, int'(v[1]));
      chk("R6 deselected after stop", int'(addressed), 0);
    end

    // burst of three data bytes
    strap = 2'b01;
    c0 = n_valid;
    bus_start();
    send_bits(8'h5A, 8); ack_clock(a1);
    send_bits(8'h12, 8); ack_clock(a2);
    chk("R5 burst ack 1", int'(a2), 1);
    send_bits(8'h34, 8); ack_clock(a2);
    send_bits(8'h56, 8); ack_clock(a2);
    chk("R5 burst ack 3", int'(a2), 1);
    chk("R5 oe released after ninth clock", int'(sda_oe), 0);
    bus_stop(); tick(20);
    chk("R2 burst count", n_valid - c0, 3);
    chk("R2 burst byte 0", int'(blog[c0 % 16]), 8'h12);
    chk("R2 burst byte 2", int'(blog[(c0 + 2) % 16]), 8'h56);

    // repeated START to a different device
    c0 = n_valid; p0 = n_stop;
    bus_start();
    send_bits(8'h5A, 8); ack_clock(a1);
    send_bits(8'h11, 8); ack_clock(a2);
    chk("R6 selected after match", int'(addressed), 1);
    bus_start();
    chk("R6 deselected on repeated start", int'(addressed), 0);
    send_bits(8'h5C, 8); ack_clock(a1);
    chk("R6 other address not acked", int'(a1), 0);
    chk("R6 stays deselected", int'(addressed), 0);
    bus_stop(); tick(20);
    chk("R7 no stop pulse when deselected", n_stop - p0, 0);
    chk("R2 first byte kept", n_valid - c0, 1);

    // START in the middle of a data byte
    c0 = n_valid;
    bus_start();
    send_bits(8'h5A, 8); ack_clock(a1);
    send_bits(8'hF0, 4);
    bus_start();
    send_bits(8'h5A, 8); ack_clock(a1);
    send_bits(8'h3C, 8); ack_clock(a2);
    bus_stop(); tick(20);
    chk("R9 partial byte dropped on start", n_valid - c0, 1);
    chk("R9 next byte intact", int'(blog[c0 % 16]), 8'h3C);
    chk("R9 ack after restart", int'(a2), 1);

    // STOP in the middle of a data byte
    c0 = n_valid; p0 = n_stop;
    bus_start();
    send_bits(8'h5A, 8); ack_clock(a1);
    send_bits(8'h81, 3);
    bus_stop(); tick(20);
    chk("R9 partial byte dropped on stop", n_valid - c0, 0);
    chk("R7 stop pulse while selected", n_stop - p0, 1);
    chk("R9 deselected after early stop", int'(addressed), 0);

    // glitch filter on idle bus
    s0 = n_start;
    sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(30);
    chk("R8 short dip ignored", n_start - s0, 0);
    s0 = n_start;
    sda_m = 1'b0; tick(10); sda_m = 1'b1; tick(30);
    chk("R8 long dip seen as start", n_start - s0, 1);
    chk("R8 no select from dip", int'(addressed), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R10 watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule